// File: doc/BRIEF.md
# TDM Multichannel Slot Selector

This block decides, word by word, whether each slot of a time-division-multiplexed serial frame is serviced. It holds two independent selectors, one for the transmit side and one for the receive side. Each selector counts the channel index within its own frame. A frame-sync strobe sets the count to channel 0, and a word-complete strobe moves it on by one. From the count and its configuration, the selector drives an enable output that tells the neighbouring serializer whether the current word is shifted out (transmit) or stored (receive).

Software configures each direction through a small synchronous write port and reads it back through a combinational read port. Each direction has a control register and a bank of eight 16-bit channel-enable words. Two selection modes exist. The legacy mode offers 32 selectable channels: two 16-channel partitions, each pointed at one block of the frame. The extended mode enables any of all 128 channels from a full bit map. The control register also reports which 16-channel block the frame is in now.

Top module: `tdm_slot_select`

## Requirements
- R1: After reset, every register reads 0, both channel counters are 0, and both enable outputs are 1.
- R2: While control bit 0 (multichannel on) of a direction is 0, that direction's enable output is 1 for every word, including words past channel 127.
- R3: A frame-sync sets that direction's channel to 0, and it wins over a word-complete in the same cycle. A word-complete alone adds 1. The count stops at an overflow value one past 127, and while multichannel is on, a word in the overflow state is never enabled.
- R4: In legacy mode (control bit 9 = 0, bit 0 = 1), the frame is split into 16-channel blocks b = channel/16. An even block is enabled only if b == 2*A, where A is control bits 5:4; the channel's bit (channel mod 16) is then taken from enable word 0. An odd block is enabled only if b == 2*B+1, where B is control bits 7:6; the bit is then taken from enable word 1.
- R5: In extended mode (control bit 9 = 1, bit 0 = 1), channel n is enabled exactly when bit n mod 16 of enable word n/16 is 1, for enable words 0 to 7.
- R6: The transmit and receive sides are fully independent: separate counters, strobes, control and enable words.
- R7: Control bits 3:1 are read-only and report the current block (channel/16, or 7 in the overflow state). Writes to them, and to control bits 8 and 15:10, have no effect; those other bits read 0.
- R8: Address map: address bit 4 selects the direction (0 transmit, 1 receive). Low nibble 0 is the control register, and low nibbles 8 to 15 are enable words 0 to 7. Any other low nibble reads 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 5 | Write address |
| cfg_wdata | input | 16 | Write data |
| cfg_raddr | input | 5 | Read address |
| cfg_rdata | output | 16 | Read data (combinational) |
| tx_fsync | input | 1 | Transmit frame-sync strobe |
| tx_word_done | input | 1 | Transmit word-complete strobe |
| rx_fsync | input | 1 | Receive frame-sync strobe |
| rx_word_done | input | 1 | Receive word-complete strobe |
| tx_slot_en | output | 1 | Current transmit word is serviced |
| rx_slot_en | output | 1 | Current receive word is serviced |

## Verification
The bench walks full frames of 130 words, which takes the count into the overflow state. It covers every pair of legacy partition selects, on one side, while the other side runs extended patterns. A design that mapped partitions to the wrong block parity, or used the wrong enable word, would service the wrong channels. A design that did not stop the count at the overflow value would wrap round and service channel 0 or 1 again. The bench also checks a frame-sync that lands together with a word-complete: a design that lets the increment win starts the frame at channel 1. It writes the read-only and unmapped bits: a design that stored them reads back corrupted control values. Strobes on one side only catch a design that shares state between the two directions.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;

    localparam int CH_PER_BLK = 16;
    localparam int NUM_BLK    = 8;
    localparam int MAX_CH     = CH_PER_BLK * NUM_BLK;
    localparam int CNT_W      = $clog2(MAX_CH) + 1;
    localparam int BLK_W      = $clog2(NUM_BLK);
    localparam int BIT_W      = $clog2(CH_PER_BLK);
    localparam int SEL_W      = BLK_W - 1;
    localparam int REG_W      = 16;
    localparam int NUM_DIR    = 2;

    // control register bit positions
    localparam int CB_MC_ON  = 0;
    localparam int CB_BLK_LO = 1;
    localparam int CB_SELA   = 4;
    localparam int CB_SELB   = 6;
    localparam int CB_EXT    = 9;

    typedef struct packed {
        logic             ext_mode;
        logic [SEL_W-1:0] sel_b;
        logic [SEL_W-1:0] sel_a;
        logic             mc_on;
    } ctrl_t;

    typedef enum logic [1:0] {
        AK_CTRL = 2'd0,
        AK_ENA  = 2'd1,
        AK_NONE = 2'd2
    } addr_kind_e;

    typedef logic [NUM_BLK-1:0][REG_W-1:0] ena_bank_t;

    function automatic addr_kind_e addr_kind(input logic [3:0] lo);
        if (lo[3])
            return AK_ENA;
        else if (lo == 4'd0)
            return AK_CTRL;
        else
            return AK_NONE;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.mc_on    = w[CB_MC_ON];
        c.sel_a    = w[CB_SELA +: SEL_W];
        c.sel_b    = w[CB_SELB +: SEL_W];
        c.ext_mode = w[CB_EXT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c,
                                                   input logic [BLK_W-1:0] blk);
        logic [REG_W-1:0] w;
        w = '0;
        w[CB_MC_ON]           = c.mc_on;
        w[CB_BLK_LO +: BLK_W] = blk;
        w[CB_SELA +: SEL_W]   = c.sel_a;
        w[CB_SELB +: SEL_W]   = c.sel_b;
        w[CB_EXT]             = c.ext_mode;
        return w;
    endfunction

endpackage

// File: rtl/tdm_chan_counter.sv
module tdm_chan_counter
    import tdm_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fsync,
    input  logic             word_done,
    output logic [CNT_W-1:0] chan
);
    localparam logic [CNT_W-1:0] OVF = CNT_W'(MAX_CH);

    always_ff @(posedge clk) begin
        if (rst)
            chan <= '0;
        else if (fsync)
            chan <= '0;
        else if (word_done && chan != OVF)
            chan <= chan + 1'b1;
    end
endmodule

// File: rtl/tdm_sel_regs.sv
module tdm_sel_regs
    import tdm_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [3:0]       waddr_lo,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl,
    output ena_bank_t        bank
);
    addr_kind_e kind;
    assign kind = addr_kind(waddr_lo);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (wr && kind == AK_CTRL)
            ctrl <= unpack_ctrl(wdata);
    end

    for (genvar k = 0; k < NUM_BLK; k++) begin : g_ena
        always_ff @(posedge clk) begin
            if (rst)
                bank[k] <= '0;
            else if (wr && kind == AK_ENA && waddr_lo[BLK_W-1:0] == BLK_W'(k))
                bank[k] <= wdata;
        end
    end
endmodule

// File: rtl/tdm_slot_decide.sv
module tdm_slot_decide
    import tdm_sel_pkg::*;
(
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] chan,
    input  ena_bank_t        bank,
    output logic             slot_en,
    output logic [BLK_W-1:0] cur_blk
);
    logic             beyond;
    logic [BLK_W-1:0] blk;
    logic [BIT_W-1:0] bit_i;
    logic             legacy_hit;

    assign beyond = chan[CNT_W-1];
    assign blk    = chan[BIT_W +: BLK_W];
    assign bit_i  = chan[BIT_W-1:0];

    always_comb begin
        if (!blk[0])
            legacy_hit = (blk[BLK_W-1:1] == ctrl.sel_a) && bank[0][bit_i];
        else
            legacy_hit = (blk[BLK_W-1:1] == ctrl.sel_b) && bank[1][bit_i];
    end

    always_comb begin
        if (!ctrl.mc_on)
            slot_en = 1'b1;
        else if (beyond)
            slot_en = 1'b0;
        else if (ctrl.ext_mode)
            slot_en = bank[blk][bit_i];
        else
            slot_en = legacy_hit;
    end

    assign cur_blk = beyond ? '1 : blk;
endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select
    import tdm_sel_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [4:0]  cfg_waddr,
    input  logic [15:0] cfg_wdata,
    input  logic [4:0]  cfg_raddr,
    output logic [15:0] cfg_rdata,
    input  logic        tx_fsync,
    input  logic        tx_word_done,
    input  logic        rx_fsync,
    input  logic        rx_word_done,
    output logic        tx_slot_en,
    output logic        rx_slot_en
);
    logic [NUM_DIR-1:0]            fs_v;
    logic [NUM_DIR-1:0]            wd_v;
    logic [NUM_DIR-1:0]            en_v;
    logic [NUM_DIR-1:0][CNT_W-1:0] chan_cnt;
    logic [NUM_DIR-1:0][BLK_W-1:0] blk_v;
    logic [NUM_DIR-1:0]            mc_on;
    ctrl_t     ctrl_v [NUM_DIR];
    ena_bank_t bank_v [NUM_DIR];

    assign fs_v = {rx_fsync, tx_fsync};
    assign wd_v = {rx_word_done, tx_word_done};
    assign tx_slot_en = en_v[0];
    assign rx_slot_en = en_v[1];

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        tdm_chan_counter u_cnt (
            .clk       (clk),
            .rst       (rst),
            .fsync     (fs_v[d]),
            .word_done (wd_v[d]),
            .chan      (chan_cnt[d])
        );

        tdm_sel_regs u_regs (
            .clk      (clk),
            .rst      (rst),
            .wr       (cfg_we && (cfg_waddr[4] == 1'(d))),
            .waddr_lo (cfg_waddr[3:0]),
            .wdata    (cfg_wdata),
            .ctrl     (ctrl_v[d]),
            .bank     (bank_v[d])
        );

        tdm_slot_decide u_dec (
            .ctrl    (ctrl_v[d]),
            .chan    (chan_cnt[d]),
            .bank    (bank_v[d]),
            .slot_en (en_v[d]),
            .cur_blk (blk_v[d])
        );

        assign mc_on[d] = ctrl_v[d].mc_on;
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (addr_kind(cfg_raddr[3:0]))
            AK_CTRL: cfg_rdata = pack_ctrl(ctrl_v[cfg_raddr[4]], blk_v[cfg_raddr[4]]);
            AK_ENA:  cfg_rdata = bank_v[cfg_raddr[4]][cfg_raddr[BLK_W-1:0]];
            default: cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tdm_slot_select_chk.sv
module tdm_slot_select_chk
    import tdm_sel_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_DIR-1:0]              fs_v,
    input logic [NUM_DIR-1:0]              wd_v,
    input logic [NUM_DIR-1:0]              en_v,
    input logic [NUM_DIR-1:0]              mc_on,
    input logic [NUM_DIR-1:0][CNT_W-1:0]   chan_cnt
);
    localparam logic [CNT_W-1:0] OVF = CNT_W'(MAX_CH);

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_chk
        // R1: first cycle after reset, both selectors report enabled
        a_r1_reset_enabled: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (en_v[d] && chan_cnt[d] == '0));

        // R2: multichannel off means every word serviced
        a_r2_off_all_enabled: assert property (@(posedge clk) disable iff (rst)
            !mc_on[d] |-> en_v[d]);

        // R3: frame-sync restarts the count, even with a word strobe
        a_r3_fsync_restart: assert property (@(posedge clk) disable iff (rst)
            fs_v[d] |=> (chan_cnt[d] == '0));

        // R3: a lone word strobe advances below the overflow value
        a_r3_word_step: assert property (@(posedge clk) disable iff (rst)
            (!fs_v[d] && wd_v[d] && chan_cnt[d] != OVF)
                |=> (chan_cnt[d] == $past(chan_cnt[d]) + 1'b1));

        // R3: without strobes or at overflow, the count holds
        a_r3_count_holds: assert property (@(posedge clk) disable iff (rst)
            (!fs_v[d] && (!wd_v[d] || chan_cnt[d] == OVF)) |=> $stable(chan_cnt[d]));

        // R3: overflow words are never serviced while multichannel is on
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
            (mc_on[d] && chan_cnt[d] == OVF) |-> !en_v[d]);

        // R3: the count never exceeds the overflow value
        a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
            chan_cnt[d] <= OVF);
    end
endmodule

bind tdm_slot_select tdm_slot_select_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .fs_v     (fs_v),
    .wd_v     (wd_v),
    .en_v     (en_v),
    .mc_on    (mc_on),
    .chan_cnt (chan_cnt)
);

// File: tb/tdm_slot_select_bench.sv
module tdm_slot_select_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [4:0]  cfg_waddr;
    logic [15:0] cfg_wdata;
    logic [4:0]  cfg_raddr;
    logic [15:0] cfg_rdata;
    logic        tx_fsync, tx_word_done, rx_fsync, rx_word_done;
    logic        tx_slot_en, rx_slot_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of configuration
    bit          m_mc  [2];
    bit          m_ext [2];
    int          m_sa  [2];
    int          m_sb  [2];
    logic [15:0] m_bank [2][8];

    always #4 clk = ~clk;

    tdm_slot_select u_tdm_slot_select (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .tx_fsync(tx_fsync), .tx_word_done(tx_word_done),
        .rx_fsync(rx_fsync), .rx_word_done(rx_word_done),
        .tx_slot_en(tx_slot_en), .rx_slot_en(rx_slot_en)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_en(input int d, input int ch);
        int b;
        int k;
        b = ch / 16;
        k = ch % 16;
        if (!m_mc[d]) return 1'b1;
        if (ch >= 128) return 1'b0;
        if (m_ext[d]) return m_bank[d][b][k];
        if (b % 2 == 0) return (b == 2 * m_sa[d]) && m_bank[d][0][k];
        return (b == 2 * m_sb[d] + 1) && m_bank[d][1][k];
    endfunction

    function automatic logic [15:0] ctrl_word(input int d, input int blk);
        return 16'(m_mc[d]) | 16'(blk << 1) | 16'(m_sa[d] << 4)
             | 16'(m_sb[d] << 6) | 16'(int'(m_ext[d]) << 9);
    endfunction

    task automatic wr(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_ctrl(input int d);
        wr(5'(d * 16), ctrl_word(d, 0));
    endtask

    task automatic load_bank(input int d, input int seed);
        for (int k = 0; k < 8; k++) begin
            m_bank[d][k] = 16'((seed * 40503 + k * 9157 + (k * k) * 311) ^ (seed << k));
            wr(5'(d * 16 + 8 + k), m_bank[d][k]);
        end
    endtask

    // full frame on both sides, 130 words so the count reaches overflow
    task automatic run_frame(input string tag);
        @(negedge clk);
        tx_fsync = 1'b1; rx_fsync = 1'b1;
        @(negedge clk);
        tx_fsync = 1'b0; rx_fsync = 1'b0;
        tx_word_done = 1'b1; rx_word_done = 1'b1;
        for (int i = 0; i < 130; i++) begin
            int c;
            c = (i > 128) ? 128 : i;
            cfg_raddr = 5'd0;
            #1;
            check({tag, " tx R3/R4/R5"}, 16'(tx_slot_en), 16'(exp_en(0, c)));
            check({tag, " rx R5/R6"}, 16'(rx_slot_en), 16'(exp_en(1, c)));
            check({tag, " R7 block field"}, 16'(cfg_rdata[3:1]), 16'((c >= 128) ? 7 : c / 16));
            @(negedge clk);
        end
        tx_word_done = 1'b0; rx_word_done = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        cfg_we = 0; cfg_waddr = 0; cfg_wdata = 0; cfg_raddr = 0;
        tx_fsync = 0; tx_word_done = 0; rx_fsync = 0; rx_word_done = 0;
        for (int d = 0; d < 2; d++) begin
            m_mc[d] = 0; m_ext[d] = 0; m_sa[d] = 0; m_sb[d] = 0;
            for (int k = 0; k < 8; k++) m_bank[d][k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 tx_slot_en", 16'(tx_slot_en), 16'd1);
        check("R1 rx_slot_en", 16'(rx_slot_en), 16'd1);
        for (int a = 0; a < 32; a++) begin
            cfg_raddr = 5'(a);
            #1;
            check("R1 register zero", cfg_rdata, 16'h0000);
        end

        // R2: multichannel off with banks loaded still enables every word
        load_bank(0, 3);
        load_bank(1, 7);
        run_frame("R2 off");

        // R4 legacy sweep on tx, R5 extended on rx, R6 independence
        m_mc[1] = 1; m_ext[1] = 1;
        set_ctrl(1);
        for (int sa = 0; sa < 4; sa++) begin
            for (int sb = 0; sb < 4; sb++) begin
                m_mc[0] = 1; m_ext[0] = 0; m_sa[0] = sa; m_sb[0] = sb;
                set_ctrl(0);
                load_bank(0, sa * 4 + sb + 11);
                load_bank(1, sa * 4 + sb + 29);
                run_frame("R4 legacy");
            end
        end

        // swap roles: rx legacy, tx extended
        m_ext[0] = 1; set_ctrl(0);
        m_ext[1] = 0; m_sa[1] = 2; m_sb[1] = 1; set_ctrl(1);
        load_bank(0, 101);
        load_bank(1, 202);
        run_frame("R5 swap");

        // R7: read-only and unmapped control bits ignored on write
        wr(5'd0, 16'hFD0E | ctrl_word(0, 0));
        cfg_raddr = 5'd0;
        #1;
        check("R7 ctrl readback", cfg_rdata, ctrl_word(0, 7));

        // R8: writes to unmapped addresses change nothing and read 0
        for (int a = 1; a < 8; a++) begin
            wr(5'(a), 16'hFFFF);
            wr(5'(16 + a), 16'hFFFF);
        end
        for (int a = 1; a < 8; a++) begin
            cfg_raddr = 5'(a);
            #1;
            check("R8 unmapped tx reads 0", cfg_rdata, 16'h0000);
            cfg_raddr = 5'(16 + a);
            #1;
            check("R8 unmapped rx reads 0", cfg_rdata, 16'h0000);
        end
        for (int k = 0; k < 8; k++) begin
            cfg_raddr = 5'(8 + k);
            #1;
            check("R8 tx enable word", cfg_rdata, m_bank[0][k]);
            cfg_raddr = 5'(24 + k);
            #1;
            check("R8 rx enable word", cfg_rdata, m_bank[1][k]);
        end

        // R3: fsync together with word_done gives channel 0
        m_bank[0][0] = 16'h0001; wr(5'd8, 16'h0001);
        @(negedge clk);
        tx_fsync = 1; @(negedge clk); tx_fsync = 0;
        tx_word_done = 1; repeat (5) @(negedge clk);
        tx_fsync = 1; @(negedge clk);
        tx_fsync = 0; tx_word_done = 0;
        cfg_raddr = 5'd0;
        #1;
        check("R3 fsync wins tx_slot_en", 16'(tx_slot_en), 16'd1);
        check("R3 fsync wins block", 16'(cfg_rdata[3:1]), 16'd0);
        tx_word_done = 1; @(negedge clk); tx_word_done = 0;
        check("R3 step to ch1", 16'(tx_slot_en), 16'd0);

        // R6: tx-only strobes leave rx counter in overflow (block 7)
        tx_fsync = 1; @(negedge clk); tx_fsync = 0;
        tx_word_done = 1; repeat (20) @(negedge clk); tx_word_done = 0;
        cfg_raddr = 5'd16;
        #1;
        check("R6 rx block untouched", 16'(cfg_rdata[3:1]), 16'd7);
        check("R6 rx overflow disabled", 16'(rx_slot_en), 16'd0);
        cfg_raddr = 5'd0;
        #1;
        check("R6 tx block after 20 words", 16'(cfg_rdata[3:1]), 16'd1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule